// File: doc/BRIEF.md
# Nibble-wide DRAM byte fetch sequencer

This block reads one byte per access slot from a dynamic RAM whose data path is only four bits wide. Each slot lasts eight clock cycles, with one cycle per fast phase, so eight fast phases make one slow access slot. Within a slot, the sequencer first drives a row address and pulls the row strobe low. It then reads two half-bytes. Each half-byte uses its own column address and its own column strobe pulse, and both pulses fall inside the same row-strobe low period. The two half-bytes are joined into one byte, which is delivered with a single-cycle valid pulse.

A client watches `accept_win`. While it is high, the client raises `req` together with a byte address. The slot then plays out on the memory pins over the next eight cycles. The design registers every memory-side output, so the pins change one cycle after the decision that sets them. A slot with no request leaves the memory idle. Writes, refresh and arbitration belong to other logic.

Top module: `dram_nibble_fetch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `ras_n` and `cas_n` are 1, `dram_a` is 0, `rd_valid` is 0, `rd_data` is 0 and `accept_win` is 1.
- R2: `accept_win` is high in one cycle out of every eight. The first such cycle is the one in which reset is released.
- R3: `req` is taken only at the clock edge that ends a cycle with `accept_win` high. The accepted slot then fills the eight following cycles, called bus phases 0 to 7.
- R4: `ras_n` is 0 in bus phases 0 to 4 of an accepted slot and 1 in bus phases 5 to 7.
- R5: `cas_n` is 0 only in bus phases 1 and 3, so it falls twice while `ras_n` is low.
- R6: In bus phase 0, `dram_a` carries the row, which is `byte_addr[ROW_W+COL_W-1:COL_W]` zero-extended. In phases 1 and 2 it carries `{byte_addr[COL_W-1:0],1'b0}`, and in phases 3 and 4 it carries `{byte_addr[COL_W-1:0],1'b1}`. In every other cycle it is 0.
- R7: The low half-byte is taken from `dq_in` at the edge that ends bus phase 1, and the high half-byte at the edge that ends bus phase 3. The delivered byte is `rd_data = {high, low}`.
- R8: `rd_valid` is 1 only in bus phase 4 of an accepted slot. At other times `rd_data` keeps its last value.
- R9: A `req` raised while `accept_win` is low is ignored. A slot with no accepted request keeps `ras_n` and `cas_n` at 1, keeps `dram_a` at 0, and gives no `rd_valid`.
- R10: A change of `byte_addr` after acceptance has no effect on the addresses or the data of the slot already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast phase clock, one cycle per phase |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Fetch request, taken only while `accept_win` is high |
| byte_addr | input | ROW_W+COL_W | Byte address; the upper bits select the row |
| dq_in | input | DQ_W | Half-byte data read back from the memory |
| accept_win | output | 1 | High in the cycle in which a request can be taken |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| dram_a | output | MUX_W | Multiplexed row and column address |
| rd_data | output | 2*DQ_W | Assembled byte |
| rd_valid | output | 1 | One-cycle pulse marking a new `rd_data` |

## Verification
The phase counter is the single piece of state that every output depends on. If it drifts, `accept_win`, the strobes and the address all slip together in the very next cycle, so a comparison of every pin on every clock exposes the fault at once. A wrong latched column or a wrong nibble register cannot be seen at the strobe pins. It shows up first as a wrong `dram_a` in bus phase 1 or 3, and then as a wrong `rd_data` in bus phase 4 of the same slot. Scrambling `byte_addr` during a slot, and raising `req` outside the window, show whether a stray input reaches that state before the next slot begins.

// File: rtl/dnf_pkg.sv
// Package: shared phase numbering for the nibble fetch sequencer.
// Assumes a fixed eight-phase slot; the value names the bus phase that
// the registered outputs will show in the following cycle.
package dnf_pkg;

    localparam int PHASES = 8;
    localparam int PH_W   = $clog2(PHASES);

    typedef enum logic [PH_W-1:0] {
        BP_ROW   = 3'd0,   // row on bus, row strobe falls
        BP_COLA  = 3'd1,   // low column on bus, column strobe falls
        BP_LO    = 3'd2,   // column strobe released after low nibble taken
        BP_COLB  = 3'd3,   // high column on bus, column strobe falls
        BP_HI    = 3'd4,   // column strobe released, byte delivered
        BP_RASUP = 3'd5,   // row strobe released
        BP_PRE0  = 3'd6,   // precharge
        BP_PRE1  = 3'd7    // precharge
    } bus_ph_e;

endpackage

// File: rtl/dnf_phase_ctr.sv
// Module: free-running phase counter for the access slot.
// Produces the phase whose outputs are being prepared this cycle and the
// acceptance window. Assumes the counter restarts at phase 0 on reset.
module dnf_phase_ctr
    import dnf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    output bus_ph_e ph,
    output logic    win
);

    logic [PH_W-1:0] cnt_q;

    // Advance one phase per clock, wrapping after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == PH_W'(PHASES - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expose the count as a phase and flag the acceptance cycle.
    always_comb begin
        ph  = bus_ph_e'(cnt_q);
        win = (cnt_q == '0);
    end

endmodule

// File: rtl/dnf_strobe_gen.sv
// Module: row and column strobe generator.
// Registers the active-low strobes for the bus phase named by 'ph'.
// Assumes 'go' is high only for a slot that holds an accepted request.
module dnf_strobe_gen
    import dnf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  bus_ph_e ph,
    input  logic    go,
    output logic    ras_n,
    output logic    cas_n
);

    logic ras_low_d;
    logic cas_low_d;

    // Decide which strobes are asserted in the coming bus phase.
    always_comb begin
        ras_low_d = 1'b0;
        cas_low_d = 1'b0;
        if (go) begin
            unique case (ph)
                BP_ROW:   ras_low_d = 1'b1;
                BP_COLA:  begin ras_low_d = 1'b1; cas_low_d = 1'b1; end
                BP_LO:    ras_low_d = 1'b1;
                BP_COLB:  begin ras_low_d = 1'b1; cas_low_d = 1'b1; end
                BP_HI:    ras_low_d = 1'b1;
                default:  ;
            endcase
        end
    end

    // Register the strobes so the memory sees clean edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
        end else begin
            ras_n <= ~ras_low_d;
            cas_n <= ~cas_low_d;
        end
    end

endmodule

// File: rtl/dnf_addr_mux.sv
// Module: multiplexed address driver.
// Latches the byte address when a request is taken, then drives the row and
// the two column addresses (half-byte select in bit 0). Drives zero when idle.
// Assumes 'take' pulses only at phase 0 and MUX_W covers row and column.
module dnf_addr_mux
    import dnf_pkg::*;
#(
    parameter int ROW_W = 7,
    parameter int COL_W = 7,
    parameter int MUX_W = 8,
    localparam int AW = ROW_W + COL_W
)(
    input  logic             clk,
    input  logic             rst_n,
    input  bus_ph_e          ph,
    input  logic             go,
    input  logic             take,
    input  logic [AW-1:0]    byte_addr,
    output logic [MUX_W-1:0] dram_a
);

    logic [COL_W-1:0] col_q;
    logic [MUX_W-1:0] a_d;
    logic [ROW_W-1:0] row_in;

    // Keep the column part of the accepted address for the whole slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (take) begin
            col_q <= byte_addr[COL_W-1:0];
        end
    end

    // Choose the value for the coming bus phase.
    always_comb begin
        row_in = byte_addr[AW-1:COL_W];
        a_d    = '0;
        if (go) begin
            unique case (ph)
                BP_ROW:          a_d = MUX_W'(row_in);
                BP_COLA, BP_LO:  a_d = MUX_W'({col_q, 1'b0});
                BP_COLB, BP_HI:  a_d = MUX_W'({col_q, 1'b1});
                default:         a_d = '0;
            endcase
        end
    end

    // Register the address bus alongside the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dram_a <= '0;
        end else begin
            dram_a <= a_d;
        end
    end

endmodule

// File: rtl/dnf_nibble_asm.sv
// Module: half-byte capture and byte assembly.
// Takes the low half-byte at the edge that ends bus phase 1 and the high one
// at the edge that ends bus phase 3, then presents the byte with a pulse.
// Assumes 'active' stays high for the whole accepted slot.
module dnf_nibble_asm
    import dnf_pkg::*;
#(
    parameter int DQ_W = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ph_e           ph,
    input  logic              active,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [2*DQ_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [DQ_W-1:0] lo_q;

    // Hold the low half-byte until its partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (active && ph == BP_LO) begin
            lo_q <= dq_in;
        end
    end

    // Join both halves and raise the valid pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= active && (ph == BP_HI);
            if (active && ph == BP_HI) begin
                rd_data <= {dq_in, lo_q};
            end
        end
    end

endmodule

// File: rtl/dram_nibble_fetch.sv
// Module: top of the nibble-wide byte fetch sequencer.
// Accepts one request per eight-cycle slot while accept_win is high and
// plays the row / two-column read sequence on the memory pins.
// Assumes dq_in is valid while cas_n is low.
module dram_nibble_fetch
    import dnf_pkg::*;
#(
    parameter int ROW_W = 7,
    parameter int COL_W = 7,
    parameter int DQ_W  = 4,
    localparam int AW    = ROW_W + COL_W,
    localparam int MUX_W = (ROW_W > COL_W + 1) ? ROW_W : COL_W + 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [AW-1:0]     byte_addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic              accept_win,
    output logic              ras_n,
    output logic              cas_n,
    output logic [MUX_W-1:0]  dram_a,
    output logic [2*DQ_W-1:0] rd_data,
    output logic              rd_valid
);

    bus_ph_e ph;
    logic    win;
    logic    take;
    logic    active_q;
    logic    go;

    dnf_phase_ctr u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .ph    (ph),
        .win   (win)
    );

    // Accept at phase 0 only; later phases follow the stored decision.
    always_comb begin
        take       = win && req;
        go         = win ? req : active_q;
        accept_win = win;
    end

    // Remember whether the current slot carries a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (win) begin
            active_q <= req;
        end
    end

    dnf_strobe_gen u_strb (
        .clk   (clk),
        .rst_n (rst_n),
        .ph    (ph),
        .go    (go),
        .ras_n (ras_n),
        .cas_n (cas_n)
    );

    dnf_addr_mux #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .MUX_W (MUX_W)
    ) u_amux (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph        (ph),
        .go        (go),
        .take      (take),
        .byte_addr (byte_addr),
        .dram_a    (dram_a)
    );

    dnf_nibble_asm #(
        .DQ_W (DQ_W)
    ) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph       (ph),
        .active   (active_q),
        .dq_in    (dq_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/dnf_checker.sv
// Module: port-level properties of the fetch sequencer, bound to its top.
module dnf_checker #(
    parameter int MUX_W = 8,
    parameter int DQ_W  = 4
)(
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              accept_win,
    input logic              ras_n,
    input logic              cas_n,
    input logic [MUX_W-1:0]  dram_a,
    input logic [2*DQ_W-1:0] rd_data,
    input logic              rd_valid
);

    // The acceptance window never lasts two cycles.
    assert_win_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_win |=> !accept_win);

    // The row strobe falls only after a request taken in the window.
    assert_ras_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(accept_win) && $past(req)));

    // The column strobe is low only inside a row strobe low period.
    assert_cas_under_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // The address bus rests at zero whenever the row strobe is high.
    assert_addr_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ras_n |-> (dram_a == '0));

    // The byte appears with the row strobe low and the column strobe high.
    assert_valid_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!ras_n && cas_n));

    // The valid pulse is one cycle long.
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // Read data changes only together with the valid pulse.
    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data));

endmodule

bind dram_nibble_fetch dnf_checker #(
    .MUX_W (MUX_W),
    .DQ_W  (DQ_W)
) u_dnf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .accept_win (accept_win),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .dram_a     (dram_a),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
);

// File: tb/dram_nibble_fetch_test.sv
`timescale 1ns/1ps
module dram_nibble_fetch_test;

    localparam int ROW_W = 7;
    localparam int COL_W = 7;
    localparam int DQ_W  = 4;
    localparam int AW    = ROW_W + COL_W;
    localparam int MUX_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic [AW-1:0]     byte_addr = '0;
    logic [DQ_W-1:0]   dq_in;
    logic              accept_win;
    logic              ras_n;
    logic              cas_n;
    logic [MUX_W-1:0]  dram_a;
    logic [2*DQ_W-1:0] rd_data;
    logic              rd_valid;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int t0     = -100;
    int a0     = 0;
    int exp_data = 0;
    bit done   = 0;
    string ctx = "R1";

    always #5 clk = ~clk;

    dram_nibble_fetch #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .byte_addr(byte_addr),
        .dq_in(dq_in), .accept_win(accept_win), .ras_n(ras_n), .cas_n(cas_n),
        .dram_a(dram_a), .rd_data(rd_data), .rd_valid(rd_valid));

    // Memory content as a function of row and half-byte column.
    function automatic logic [3:0] nib(input int r, input int c);
        return 4'((r * 5 + c * 3 + (r >> 1) + 9) ^ (c >> 3));
    endfunction

    // Behavioural memory: latch row and column on strobe falls.
    int row_l = 0;
    int col_l = 0;
    always @(negedge ras_n) begin #1; row_l = int'(dram_a); end
    always @(negedge cas_n) begin #1; col_l = int'(dram_a); end
    assign dq_in = !cas_n ? nib(row_l, col_l) : 4'h0;

    task automatic chk(input string tag, input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s (%s) %s cycle %0d: got %0h expected %0h", tag, ctx, what, cyc, got, exp);
        end
    endtask

    // Compare every output against the reference for the current cycle.
    task automatic compare();
        int k;
        int p;
        int e_ras;
        int e_cas;
        int e_a;
        int e_v;
        int cb;
        string itag;
        k = cyc - t0;
        p = (k >= 1 && k <= 8) ? k - 1 : -1;
        cb = a0 & ((1 << COL_W) - 1);
        e_ras = (p >= 0 && p <= 4) ? 0 : 1;
        e_cas = (p == 1 || p == 3) ? 0 : 1;
        e_v   = (p == 4) ? 1 : 0;
        case (p)
            0:       e_a = a0 >> COL_W;
            1, 2:    e_a = cb * 2;
            3, 4:    e_a = cb * 2 + 1;
            default: e_a = 0;
        endcase
        if (p == 4) exp_data = (int'(nib(a0 >> COL_W, cb * 2 + 1)) << 4) | int'(nib(a0 >> COL_W, cb * 2));
        itag = (p < 0) ? "R9" : "";
        chk("R2", int'(accept_win), (cyc % 8 == 0) ? 1 : 0, "accept_win");
        chk((p < 0) ? itag : "R4", int'(ras_n), e_ras, "ras_n");
        chk((p < 0) ? itag : "R5", int'(cas_n), e_cas, "cas_n");
        chk((p < 0) ? itag : "R6", int'(dram_a), e_a, "dram_a");
        chk((p < 0) ? itag : "R8", int'(rd_valid), e_v, "rd_valid");
        chk("R7", int'(rd_data), exp_data, "rd_data");
    endtask

    // One cycle: check outputs, then drive inputs for this cycle's edge.
    task automatic step(input logic r, input logic [AW-1:0] a);
        @(negedge clk);
        compare();
        rst_n     = 1'b1;
        req       = r;
        byte_addr = a;
        if (r && (cyc % 8 == 0)) begin   // R3: taken only in the window
            t0 = cyc;
            a0 = int'(a);
        end
        cyc++;
    endtask

    // One slot; bad_at raises a stray request, scramble alters the address (R10).
    task automatic run_slot(input bit do_req, input logic [AW-1:0] a,
                            input int bad_at, input bit scramble);
        for (int i = 0; i < 8; i++) begin
            logic r;
            logic [AW-1:0] aa;
            r  = (i == 0) ? do_req : (i == bad_at);
            aa = (i == 0 || !scramble) ? a : (~a + AW'(i));
            step(r, aa);
        end
    endtask

    initial begin
        // R1: outputs during reset.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1", int'(ras_n), 1, "ras_n in reset");
            chk("R1", int'(cas_n), 1, "cas_n in reset");
            chk("R1", int'(dram_a), 0, "dram_a in reset");
            chk("R1", int'(rd_valid), 0, "rd_valid in reset");
            chk("R1", int'(rd_data), 0, "rd_data in reset");
            chk("R1", int'(accept_win), 1, "accept_win in reset");
        end
        ctx = "R6";
        run_slot(1'b1, 14'h0000, -1, 1'b0);
        run_slot(1'b1, 14'h3FFF, -1, 1'b0);
        run_slot(1'b1, 14'h1555, -1, 1'b0);
        run_slot(1'b1, 14'h2AAA, -1, 1'b0);
        ctx = "R9";
        run_slot(1'b0, 14'h1234, -1, 1'b0);
        run_slot(1'b0, 14'h0F0F, 3, 1'b0);
        run_slot(1'b0, 14'h3C3C, 7, 1'b0);
        ctx = "R3";
        run_slot(1'b1, 14'h0421, 5, 1'b0);
        ctx = "R10";
        run_slot(1'b1, 14'h2B7E, -1, 1'b1);
        run_slot(1'b1, 14'h0081, 2, 1'b1);
        ctx = "R7";
        for (int s = 0; s < 24; s++) begin
            run_slot(1'b1, AW'(s * 16'h03A7 + 16'h0011), -1, s[0]);
        end
        ctx = "R9";
        run_slot(1'b0, 14'h0000, -1, 1'b0);
        run_slot(1'b0, 14'h0000, -1, 1'b0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule